// File: doc/BRIEF.md
# Compact Dual-Stack Processor Core

A small processor with no register file. Each instruction is one byte and names no operand. Arithmetic and logic work on the top two entries of a data stack, and the result replaces them. Subroutine return addresses are kept on a separate return stack. The top data entry is held in a register. The entries below it sit in a single-port stack memory, so an operation that needs a second operand spends an extra cycle popping it before it computes.

The core reads bytes from an instruction memory through a combinational fetch port. It reads and writes 16-bit words through one data memory port. Load, store, call and conditional jump take their address from the data stack rather than from inline operands. The core stops on a halt opcode, or on any push to a full stack or pop from an empty stack. The second case also raises a sticky error flag.

Top module: `stk_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0, empties both stacks, and clears the halted and error flags.
- R2: Opcode 0x01 pushes the following instruction byte, sign-extended to the data width. Execution continues after that byte.
- R3: Opcodes 0x02 add, 0x03 subtract (second entry minus top), 0x04 and, 0x05 or and 0x06 xor each pop two entries and push their result.
- R4: Opcode 0x07 duplicates the top entry, 0x08 discards it, and 0x09 exchanges the top two entries.
- R5: Opcode 0x0A replaces the top entry (an address) with the data word read there. Opcode 0x0B writes the second entry to the address in the top entry, pops both, and pulses the write strobe for exactly one cycle.
- R6: Opcode 0x0C pops a target (top) and a condition (second). It jumps to the target only when the condition is zero.
- R7: Opcode 0x0D pops a target and pushes the address of the next instruction onto the return stack before jumping. Opcode 0x0E pops the return stack into the program counter.
- R8: Opcode 0x00 raises the halted flag. After that, the fetch address stays frozen and no data write occurs until reset.
- R9: Pushing onto a full stack or popping from an empty stack (data or return) sets the error flag and halts the core. The error flag stays set until reset.
- R10: Any opcode outside 0x00 to 0x0E has no effect other than advancing to the next instruction.
- R11: Each stack holds 16 entries. Sixteen pushes succeed, and a seventeenth is an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction byte address (program counter) |
| imem_data | input | 8 | Instruction byte at imem_addr, combinational |
| dmem_addr | output | 16 | Data memory word address |
| dmem_wdata | output | 16 | Data memory write value |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 16 | Data word at dmem_addr, combinational |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bound checker watches these properties on every cycle:
- the reset values of the program counter, flags and stack counts;
- that the error flag is sticky and always brings halted with it;
- that a halted core neither moves its fetch address nor writes memory;
- that neither stack count passes its depth.

Only the bench's programs can show that the arithmetic results, the operand order of subtract and swap, sign extension of literals, taken and untaken branches, and call/return nesting order are correct. The bench observes these through the stream of data memory writes. It also drives programs that fill each stack exactly to depth and one entry past it.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [7:0] {
      OP_HALT  = 8'h00,
      OP_LIT   = 8'h01,
      OP_ADD   = 8'h02,
      OP_SUB   = 8'h03,
      OP_AND   = 8'h04,
      OP_OR    = 8'h05,
      OP_XOR   = 8'h06,
      OP_DUP   = 8'h07,
      OP_DROP  = 8'h08,
      OP_SWAP  = 8'h09,
      OP_LOAD  = 8'h0A,
      OP_STORE = 8'h0B,
      OP_JZ    = 8'h0C,
      OP_CALL  = 8'h0D,
      OP_RET   = 8'h0E
   } op_e;

   typedef enum logic [1:0] {
      ST_FETCH,
      ST_EXEC,
      ST_OP,
      ST_HALT
   } state_e;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_XOR
   } alu_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
   import stk_pkg::*;
#(
   parameter int DW = 16
) (
   input  alu_e          fn,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   always_comb begin
      case (fn)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_XOR: y = a ^ b;
         default: y = a + b;
      endcase
   end
endmodule

// File: rtl/stk_lifo_mem.sv
module stk_lifo_mem #(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/stk_core.sv
module stk_core
   import stk_pkg::*;
#(
   parameter int DW       = 16,
   parameter int PCW      = 8,
   parameter int DS_DEPTH = 16,
   parameter int RS_DEPTH = 16
) (
   input  logic           clk,
   input  logic           rst,
   output logic [PCW-1:0] imem_addr,
   input  logic [7:0]     imem_data,
   output logic [DW-1:0]  dmem_addr,
   output logic [DW-1:0]  dmem_wdata,
   output logic           dmem_we,
   input  logic [DW-1:0]  dmem_rdata,
   output logic           halted,
   output logic           err
);
   localparam int DCW = $clog2(DS_DEPTH + 1);
   localparam int DAW = $clog2(DS_DEPTH);
   localparam int RCW = $clog2(RS_DEPTH + 1);
   localparam int RAW = $clog2(RS_DEPTH);
   localparam logic [DCW-1:0] D_FULL = DCW'(DS_DEPTH);
   localparam logic [RCW-1:0] R_FULL = RCW'(RS_DEPTH);

   initial begin
      assert (DW >= 8 && DW >= PCW) else $error("data width too small");
      assert (DS_DEPTH >= 2 && RS_DEPTH >= 2) else $error("stack depth too small");
   end

   state_e         state_q, state_d;
   logic [PCW-1:0] pc_q, pc_d;
   logic [7:0]     ir_q, ir_d;
   logic [DW-1:0]  tos_q, tos_d, nos_q, nos_d;
   logic [DCW-1:0] dcnt_q, dcnt_d;
   logic [RCW-1:0] rcnt_q, rcnt_d;
   logic           err_q, err_d;

   logic           ds_we, rs_we;
   logic [DAW-1:0] ds_addr;
   logic [RAW-1:0] rs_addr;
   logic [DW-1:0]  ds_wdata, ds_rdata, alu_y, lit;
   logic [PCW-1:0] rs_wdata, rs_rdata;
   alu_e           alu_fn;

   logic [DCW-1:0] dm1, dm2;
   logic [RCW-1:0] rm1;
   assign dm1 = dcnt_q - DCW'(1);
   assign dm2 = dcnt_q - DCW'(2);
   assign rm1 = rcnt_q - RCW'(1);

   generate
      if (DW > 8) begin : g_lit_sext
         assign lit = {{(DW-8){imem_data[7]}}, imem_data};
      end else begin : g_lit_plain
         assign lit = imem_data;
      end
   endgenerate

   stk_lifo_mem #(.W(DW), .DEPTH(DS_DEPTH)) u_dstk (
      .clk(clk), .we(ds_we), .addr(ds_addr), .wdata(ds_wdata), .rdata(ds_rdata));

   stk_lifo_mem #(.W(PCW), .DEPTH(RS_DEPTH)) u_rstk (
      .clk(clk), .we(rs_we), .addr(rs_addr), .wdata(rs_wdata), .rdata(rs_rdata));

   stk_alu #(.DW(DW)) u_alu (.fn(alu_fn), .a(nos_q), .b(tos_q), .y(alu_y));

   always_comb begin
      case (ir_q)
         OP_SUB:  alu_fn = ALU_SUB;
         OP_AND:  alu_fn = ALU_AND;
         OP_OR:   alu_fn = ALU_OR;
         OP_XOR:  alu_fn = ALU_XOR;
         default: alu_fn = ALU_ADD;
      endcase
   end

   always_comb begin
      state_d = state_q; pc_d = pc_q; ir_d = ir_q;
      tos_d = tos_q; nos_d = nos_q; dcnt_d = dcnt_q; rcnt_d = rcnt_q; err_d = err_q;
      ds_we = 1'b0; ds_addr = dm1[DAW-1:0]; ds_wdata = tos_q;
      rs_we = 1'b0; rs_addr = rcnt_q[RAW-1:0]; rs_wdata = pc_q;
      dmem_we = 1'b0; dmem_addr = tos_q; dmem_wdata = nos_q;
      case (state_q)
         ST_FETCH: begin
            ir_d    = imem_data;
            pc_d    = pc_q + PCW'(1);
            state_d = ST_EXEC;
         end
         ST_EXEC: begin
            state_d = ST_FETCH;
            case (ir_q)
               OP_HALT: state_d = ST_HALT;
               OP_LIT, OP_DUP: begin
                  if (dcnt_q == D_FULL || (ir_q == OP_DUP && dcnt_q == '0)) begin
                     err_d = 1'b1; state_d = ST_HALT;
                  end else begin
                     ds_we  = (dcnt_q != '0);
                     dcnt_d = dcnt_q + DCW'(1);
                     if (ir_q == OP_LIT) begin
                        tos_d = lit;
                        pc_d  = pc_q + PCW'(1);
                     end
                  end
               end
               OP_DROP: begin
                  if (dcnt_q == '0) begin
                     err_d = 1'b1; state_d = ST_HALT;
                  end else begin
                     ds_addr = dm2[DAW-1:0];
                     if (dcnt_q > DCW'(1)) tos_d = ds_rdata;
                     dcnt_d = dm1;
                  end
               end
               OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SWAP, OP_STORE, OP_JZ: begin
                  if (dcnt_q < DCW'(2)) begin
                     err_d = 1'b1; state_d = ST_HALT;
                  end else begin
                     ds_addr = dm2[DAW-1:0];
                     nos_d   = ds_rdata;
                     dcnt_d  = dm1;
                     state_d = ST_OP;
                  end
               end
               OP_LOAD: begin
                  if (dcnt_q == '0) begin
                     err_d = 1'b1; state_d = ST_HALT;
                  end else begin
                     tos_d = dmem_rdata;
                  end
               end
               OP_CALL: begin
                  if (dcnt_q == '0 || rcnt_q == R_FULL) begin
                     err_d = 1'b1; state_d = ST_HALT;
                  end else begin
                     rs_we   = 1'b1;
                     rcnt_d  = rcnt_q + RCW'(1);
                     pc_d    = tos_q[PCW-1:0];
                     ds_addr = dm2[DAW-1:0];
                     if (dcnt_q > DCW'(1)) tos_d = ds_rdata;
                     dcnt_d  = dm1;
                  end
               end
               OP_RET: begin
                  if (rcnt_q == '0) begin
                     err_d = 1'b1; state_d = ST_HALT;
                  end else begin
                     rs_addr = rm1[RAW-1:0];
                     pc_d    = rs_rdata;
                     rcnt_d  = rm1;
                  end
               end
               default: ;
            endcase
         end
         ST_OP: begin
            state_d = ST_FETCH;
            case (ir_q)
               OP_SWAP: begin
                  ds_we  = 1'b1;
                  tos_d  = nos_q;
                  dcnt_d = dcnt_q + DCW'(1);
               end
               OP_STORE, OP_JZ: begin
                  if (ir_q == OP_STORE) dmem_we = 1'b1;
                  else if (nos_q == '0) pc_d = tos_q[PCW-1:0];
                  ds_addr = dm2[DAW-1:0];
                  if (dcnt_q > DCW'(1)) tos_d = ds_rdata;
                  dcnt_d = dm1;
               end
               default: tos_d = alu_y;
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_FETCH; pc_q <= '0; ir_q <= '0;
         tos_q <= '0; nos_q <= '0; dcnt_q <= '0; rcnt_q <= '0; err_q <= 1'b0;
      end else begin
         state_q <= state_d; pc_q <= pc_d; ir_q <= ir_d;
         tos_q <= tos_d; nos_q <= nos_d; dcnt_q <= dcnt_d; rcnt_q <= rcnt_d; err_q <= err_d;
      end
   end

   assign imem_addr = pc_q;
   assign halted    = (state_q == ST_HALT);
   assign err       = err_q;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
   parameter int PCW      = 8,
   parameter int DS_DEPTH = 16,
   parameter int RS_DEPTH = 16,
   parameter int DCW      = 5,
   parameter int RCW      = 5
) (
   input logic           clk,
   input logic           rst,
   input logic [PCW-1:0] imem_addr,
   input logic           dmem_we,
   input logic           halted,
   input logic           err,
   input logic [DCW-1:0] dcnt,
   input logic [RCW-1:0] rcnt
);
   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (imem_addr == '0 && !halted && !err && dcnt == '0 && rcnt == '0));
   // R9
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);
   a_r9_err_halts: assert property (@(posedge clk) disable iff (rst) err |-> halted);
   // R8
   a_r8_halt_freeze: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(imem_addr)));
   a_r8_no_write_halted: assert property (@(posedge clk) disable iff (rst) halted |-> !dmem_we);
   // R11
   a_r11_depth_bound: assert property (@(posedge clk) disable iff (rst)
      (dcnt <= DCW'(DS_DEPTH)) && (rcnt <= RCW'(RS_DEPTH)));
endmodule

bind stk_core stk_core_chk #(
   .PCW(PCW), .DS_DEPTH(DS_DEPTH), .RS_DEPTH(RS_DEPTH), .DCW(DCW), .RCW(RCW)
) u_chk (
   .clk(clk), .rst(rst), .imem_addr(imem_addr), .dmem_we(dmem_we),
   .halted(halted), .err(err), .dcnt(dcnt_q), .rcnt(rcnt_q)
);

// File: tb/stk_core_bench.sv
module stk_core_bench;
   localparam logic [7:0] HALT = 8'h00, LIT = 8'h01, ADD = 8'h02, SUB = 8'h03,
      AND_ = 8'h04, OR_ = 8'h05, XOR_ = 8'h06, DUP = 8'h07, DROP = 8'h08,
      SWAP = 8'h09, LOAD = 8'h0A, STORE = 8'h0B, JZ = 8'h0C, CALL = 8'h0D, RET = 8'h0E;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [7:0]  imem_addr, imem_data;
   logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, halted, err;
   logic [7:0]  imem [256];
   logic [15:0] dmem [256];

   assign imem_data  = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr[7:0]];
   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

   stk_core u_stk_core (
      .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata), .halted(halted), .err(err));

   int checks = 0;
   int errors = 0;
   int wp = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // scoreboard monitor: every write must match the next expected store
   always @(negedge clk) begin
      if (!rst && dmem_we) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected store actual=%h expected=none (R5/R8)",
                     {dmem_addr, dmem_wdata});
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if ({dmem_addr, dmem_wdata} !== e) begin
               errors++;
               $display("FAIL %s store actual=%h expected=%h", t, {dmem_addr, dmem_wdata}, e);
            end
         end
      end
   end

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) begin
         imem[i] = HALT;
         dmem[i] = '0;
      end
      wp = 0;
   endtask

   task automatic emit(logic [7:0] b);
      imem[wp] = b;
      wp++;
   endtask

   task automatic lit(logic [7:0] v);
      emit(LIT);
      emit(v);
   endtask

   task automatic expect_store(string req, logic [15:0] a, logic [15:0] d);
      exp_q.push_back({a, d});
      tag_q.push_back(req);
   endtask

   task automatic run(string req, logic exp_err);
      int n;
      logic [7:0] frozen;
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset pc", {24'd0, imem_addr}, 32'd0);
      chk("R1 reset halted", {31'd0, halted}, 32'd0);
      chk("R1 reset err", {31'd0, err}, 32'd0);
      rst = 1'b0;
      n = 0;
      while (!halted && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk({req, " halted"}, {31'd0, halted}, 32'd1);
      chk({req, " R9 err flag"}, {31'd0, err}, {31'd0, exp_err});
      chk({req, " pending stores"}, exp_q.size(), 32'd0);
      frozen = imem_addr;
      repeat (5) @(negedge clk);
      chk("R8 pc frozen", {24'd0, imem_addr}, {24'd0, frozen});
      chk("R9 err held", {31'd0, err}, {31'd0, exp_err});
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      // R2 R3: literals and ALU
      clear_prog();
      lit(8'd5); lit(8'd3); emit(ADD); lit(8'h10); emit(STORE); expect_store("R3 add", 16'h10, 16'd8);
      lit(8'd5); lit(8'd3); emit(SUB); lit(8'h11); emit(STORE); expect_store("R3 sub", 16'h11, 16'd2);
      lit(8'hFE); lit(8'h12); emit(STORE); expect_store("R2 sext", 16'h12, 16'hFFFE);
      lit(8'h0C); lit(8'h0A); emit(AND_); lit(8'h13); emit(STORE); expect_store("R3 and", 16'h13, 16'h8);
      lit(8'h0C); lit(8'h0A); emit(OR_); lit(8'h14); emit(STORE); expect_store("R3 or", 16'h14, 16'hE);
      lit(8'h0C); lit(8'h0A); emit(XOR_); lit(8'h15); emit(STORE); expect_store("R3 xor", 16'h15, 16'h6);
      lit(8'd3); lit(8'd5); emit(SUB); lit(8'h16); emit(STORE); expect_store("R3 sub order", 16'h16, 16'hFFFE);
      lit(8'h7F); lit(8'h17); emit(STORE); expect_store("R2 positive", 16'h17, 16'h007F);
      emit(HALT);
      run("R3", 1'b0);

      // R4 R5: stack shuffles, load, store
      clear_prog();
      dmem[8'h30] = 16'h1234;
      lit(8'd7); emit(DUP); emit(ADD); lit(8'h20); emit(STORE); expect_store("R4 dup", 16'h20, 16'd14);
      lit(8'd1); lit(8'd9); emit(SWAP);
      lit(8'h21); emit(STORE); expect_store("R4 swap top", 16'h21, 16'd1);
      lit(8'h22); emit(STORE); expect_store("R4 swap second", 16'h22, 16'd9);
      lit(8'd4); lit(8'd6); emit(DROP); lit(8'h23); emit(STORE); expect_store("R4 drop", 16'h23, 16'd4);
      lit(8'h30); emit(LOAD); lit(8'h24); emit(STORE); expect_store("R5 load", 16'h24, 16'h1234);
      emit(HALT);
      run("R5", 1'b0);

      // R6 R7: branches, call and return
      clear_prog();
      lit(8'd0); lit(8'd7); emit(JZ);          // 0..4 taken to 7
      emit(HALT); emit(HALT);                   // 5,6 skipped
      lit(8'd1); lit(8'd12); emit(JZ);         // 7..11 not taken
      lit(8'd90); lit(8'h40); emit(STORE);     // 12..16
      expect_store("R6 branch", 16'h40, 16'd90);
      lit(8'd30); emit(CALL);                  // 17..19
      expect_store("R7 callee", 16'h42, 16'd77);
      lit(8'd66); lit(8'h41); emit(STORE);     // 20..24
      expect_store("R7 after return", 16'h41, 16'd66);
      emit(HALT);                               // 25
      wp = 30;
      lit(8'd77); lit(8'h42); emit(STORE); emit(RET);
      run("R6", 1'b0);

      // R10: undefined opcode is a no-op
      clear_prog();
      lit(8'd9); emit(8'h3F); emit(8'hFF); lit(8'h50); emit(STORE);
      expect_store("R10 undefined", 16'h50, 16'd9);
      emit(HALT);
      run("R10", 1'b0);

      // R9: data underflow
      clear_prog();
      emit(ADD);
      run("R9 data underflow", 1'b1);

      // R9: return underflow
      clear_prog();
      emit(RET);
      run("R9 return underflow", 1'b1);

      // R11: exactly sixteen data entries
      clear_prog();
      for (int i = 0; i < 16; i++) lit(8'd1);
      emit(HALT);
      run("R11 data full", 1'b0);

      // R11: seventeenth data push
      clear_prog();
      for (int i = 0; i < 17; i++) lit(8'd1);
      emit(HALT);
      run("R11 data overflow", 1'b1);

      // R11: unbounded recursion overflows the return stack
      clear_prog();
      lit(8'd0); emit(CALL);
      run("R11 return overflow", 1'b1);

      finish_run();
   end
endmodule